// File: doc/BRIEF.md
# Periodic Wakeup Timer

This block counts a once-per-second tick down from a programmed reload value and raises a wakeup flag each time the count runs out, which is every reload+1 ticks. It then reloads and keeps running for as long as it is enabled. An extended mode adds 2^16 to the count, so the period can reach about 36 hours. The flag appears at a fixed bit of a status word and is cleared by a write-one-to-clear strobe. A separate interrupt enable decides whether the flag drives the interrupt line.

The reload value and the mode can only be changed while the timer is stopped. Software first drops the enable and then waits until the write-allowed output goes high. It then writes the new settings and raises the enable again. Both edges of the write-allowed output take effect only after a tick has been seen, which mirrors the clock-domain handover of a real timer. Each re-enable starts a fresh count from the reload value.

Top module: `wkt_wakeup_timer`

## Requirements
- R1: After reset, `cfg_ok_o` is 1, `status_o` is all zeros and `irq_o` is 0.
- R2: A configuration write (`cfg_wr_i`) is stored only while `cfg_ok_o` is 1. A write made while the timer runs is ignored, and the period in use does not change.
- R3: After `en_i` rises, `cfg_ok_o` stays 1 until the first tick that arrives at least two clocks later. It falls one clock after that tick, and the count is loaded with the reload value at that moment.
- R4: After `en_i` falls, counting stops at once and `cfg_ok_o` stays 0 until the first tick that arrives at least two clocks later. It rises one clock after that tick. Ticks seen while the timer is stopped never set the flag.
- R5: While running with reload value R, the flag sets at the clock edge of every (R+1)-th counted tick.
- R6: When the extended bit is 1, the period is R + 65537 ticks.
- R7: A disable followed by a re-enable throws away any partial count. The first expiry comes R+1 ticks after the new start.
- R8: The flag is bit 2 of `status_o`, and all other status bits read 0. A `clr_wr_i` strobe clears the flag only if bit 2 of `clr_data_i` is 1. Other data bits have no effect.
- R9: If an expiry and a clearing write fall in the same clock, the flag ends up set.
- R10: Later expiries leave an already set flag at 1, and no other status bit changes.
- R11: `irq_o` is 1 exactly when the flag is set and `irq_en_i` is 1.
- R12: With reload value 0, every counted tick sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-clock pulse per second, counted while running |
| en_i | input | 1 | Timer enable level |
| irq_en_i | input | 1 | Lets the flag onto the interrupt line |
| cfg_wr_i | input | 1 | Strobe that stores reload value and extended bit |
| cfg_reload_i | input | CNT_W (16) | Reload value |
| cfg_ext_i | input | 1 | Extended mode: adds 2^CNT_W to the count |
| clr_wr_i | input | 1 | Write strobe for the clear word |
| clr_data_i | input | STAT_W (8) | Clear word; a 1 in bit 2 clears the flag |
| cfg_ok_o | output | 1 | Configuration writes are allowed |
| status_o | output | STAT_W (8) | Status word; flag in bit 2 |
| irq_o | output | 1 | Interrupt request |

## Verification
A tick that makes the count expire and a clearing write can arrive in the same clock, and the flag must end up set in that case. The bench provokes this on purpose: it steps the count to one tick before expiry with the flag already cleared, then drives the last tick and a full clear word together. Randomly mixed ticks and clears cover the same collision many more times. A model in the bench gives set priority over clear and compares the status word and the interrupt after every step.

// File: rtl/wkt_pkg.sv
package wkt_pkg;

    // Phases of the enable/write-allowed handover.
    typedef enum logic [2:0] {
        HS_OFF  = 3'd0,   // stopped, writes allowed
        HS_ARM  = 3'd1,   // enable seen, waiting for a tick
        HS_GO   = 3'd2,   // tick seen, start on the next clock
        HS_RUN  = 3'd3,   // counting
        HS_STOP = 3'd4,   // enable dropped, waiting for a tick
        HS_HALT = 3'd5    // tick seen, writes allowed on the next clock
    } hs_state_e;

    localparam int unsigned WKT_FLAG_POS = 2;

endpackage

// File: rtl/wkt_handshake.sv
module wkt_handshake
    import wkt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic tick_i,
    output logic cfg_ok_o,
    output logic load_o,
    output logic run_o
);

    typedef struct packed {
        logic      en;
        hs_state_e st;
    } hs_reg_t;

    hs_reg_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.en = en_i;
        unique case (r_q.st)
            HS_OFF:  if (r_q.en) r_d.st = HS_ARM;
            HS_ARM: begin
                if (!r_q.en)     r_d.st = HS_OFF;
                else if (tick_i) r_d.st = HS_GO;
            end
            HS_GO:   r_d.st = r_q.en ? HS_RUN : HS_OFF;
            HS_RUN:  if (!r_q.en) r_d.st = HS_STOP;
            HS_STOP: if (tick_i) r_d.st = HS_HALT;
            HS_HALT: r_d.st = HS_OFF;
            default: r_d.st = HS_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.en <= 1'b0;
            r_q.st <= HS_OFF;
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg_ok_o = (r_q.st == HS_OFF) || (r_q.st == HS_ARM) || (r_q.st == HS_GO);
    assign load_o   = (r_q.st == HS_GO) && r_q.en;
    assign run_o    = (r_q.st == HS_RUN) && r_q.en;

    // R3/R4: write-allowed only moves out of the two handover phases
    assert_ok_moves_on_handover_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != HS_GO && r_q.st != HS_HALT) |=> $stable(cfg_ok_o));

    // R4: stopping never grants writes without a tick
    assert_stop_waits_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == HS_STOP && !tick_i) |=> !cfg_ok_o);

    // R3: arming never withdraws writes without a tick
    assert_arm_waits_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == HS_ARM && !tick_i) |=> cfg_ok_o);

endmodule

// File: rtl/wkt_counter.sv
module wkt_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             cfg_ok_i,
    input  logic             cfg_wr_i,
    input  logic [CNT_W-1:0] cfg_reload_i,
    input  logic             cfg_ext_i,
    input  logic             load_i,
    input  logic             run_i,
    output logic             expire_o
);

    localparam int unsigned EXT_W = CNT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] reload;
        logic             ext;
        logic [EXT_W-1:0] cnt;
    } cnt_reg_t;

    cnt_reg_t r_d, r_q;
    logic [EXT_W-1:0] start_val;

    // Extended mode puts the extra bit above the reload value.
    assign start_val = {r_q.ext, r_q.reload};

    always_comb begin
        r_d      = r_q;
        expire_o = 1'b0;
        if (cfg_ok_i && cfg_wr_i) begin
            r_d.reload = cfg_reload_i;
            r_d.ext    = cfg_ext_i;
        end
        if (load_i) begin
            r_d.cnt = start_val;
        end else if (run_i && tick_i) begin
            if (r_q.cnt == '0) begin
                r_d.cnt  = start_val;
                expire_o = 1'b1;
            end else begin
                r_d.cnt = r_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.reload <= '0;
            r_q.ext    <= 1'b0;
            r_q.cnt    <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // R2: settings are frozen while writes are not allowed
    assert_cfg_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ok_i |=> ($stable(r_q.reload) && $stable(r_q.ext)));

    // R4: the count holds while stopped
    assert_count_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !load_i) |=> $stable(r_q.cnt));

    // R5: an expiry reloads the full period
    assert_reload_on_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> (r_q.cnt == $past(start_val)));

endmodule

// File: rtl/wkt_flag.sv
module wkt_flag #(
    parameter int unsigned STAT_W   = 8,
    parameter int unsigned FLAG_POS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              expire_i,
    input  logic              clr_wr_i,
    input  logic [STAT_W-1:0] clr_data_i,
    input  logic              irq_en_i,
    output logic [STAT_W-1:0] status_o,
    output logic              irq_o
);

    localparam logic [STAT_W-1:0] FLAG_MASK = STAT_W'(1) << FLAG_POS;

    typedef struct packed {
        logic flag;
    } flag_reg_t;

    flag_reg_t r_d, r_q;
    logic      clr_hit;

    assign clr_hit = clr_wr_i && ((clr_data_i & FLAG_MASK) != '0);

    always_comb begin
        r_d = r_q;
        if (expire_i)     r_d.flag = 1'b1;   // a new expiry beats a clear
        else if (clr_hit) r_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q.flag <= 1'b0;
        else        r_q      <= r_d;
    end

    for (genvar b = 0; b < STAT_W; b++) begin : g_stat
        if (b == FLAG_POS) begin : g_flag
            assign status_o[b] = r_q.flag;
        end else begin : g_zero
            assign status_o[b] = 1'b0;
        end
    end

    assign irq_o = r_q.flag & irq_en_i;

    // R9: expiry always leaves the flag set
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> status_o[FLAG_POS]);

    // R8: a matching clear without expiry drops the flag
    assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr_i && clr_data_i[FLAG_POS] && !expire_i) |=> !status_o[FLAG_POS]);

    // R8: with no expiry and no matching clear, the flag holds
    assert_flag_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!expire_i && !(clr_wr_i && clr_data_i[FLAG_POS])) |=> $stable(status_o));

endmodule

// File: rtl/wkt_wakeup_timer.sv
module wkt_wakeup_timer #(
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned STAT_W   = 8,
    parameter int unsigned FLAG_POS = wkt_pkg::WKT_FLAG_POS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              en_i,
    input  logic              irq_en_i,
    input  logic              cfg_wr_i,
    input  logic [CNT_W-1:0]  cfg_reload_i,
    input  logic              cfg_ext_i,
    input  logic              clr_wr_i,
    input  logic [STAT_W-1:0] clr_data_i,
    output logic              cfg_ok_o,
    output logic [STAT_W-1:0] status_o,
    output logic              irq_o
);

    logic load, run, expire;

    wkt_handshake u_hs (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_i),
        .tick_i   (tick_i),
        .cfg_ok_o (cfg_ok_o),
        .load_o   (load),
        .run_o    (run)
    );

    wkt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .cfg_ok_i     (cfg_ok_o),
        .cfg_wr_i     (cfg_wr_i),
        .cfg_reload_i (cfg_reload_i),
        .cfg_ext_i    (cfg_ext_i),
        .load_i       (load),
        .run_i        (run),
        .expire_o     (expire)
    );

    wkt_flag #(.STAT_W(STAT_W), .FLAG_POS(FLAG_POS)) u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .expire_i   (expire),
        .clr_wr_i   (clr_wr_i),
        .clr_data_i (clr_data_i),
        .irq_en_i   (irq_en_i),
        .status_o   (status_o),
        .irq_o      (irq_o)
    );

    // R11: the interrupt never fires without the flag
    assert_irq_needs_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> status_o[FLAG_POS]);

    // R3: running and write-allowed never overlap
    assert_run_excludes_cfg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> !cfg_ok_o);

endmodule

// File: tb/wkt_wakeup_timer_test.sv
`timescale 1ns/1ps
module wkt_wakeup_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0, en_i = 1'b0, irq_en_i = 1'b0;
    logic        cfg_wr_i = 1'b0, cfg_ext_i = 1'b0, clr_wr_i = 1'b0;
    logic [15:0] cfg_reload_i = '0;
    logic [7:0]  clr_data_i = '0;
    logic        cfg_ok_o, irq_o;
    logic [7:0]  status_o;

    int pass_n = 0, fail_n = 0, cyc = 0;
    int per = 1, k = 0;
    bit running = 0, mflag = 0;

    always #2 clk = ~clk;

    wkt_wakeup_timer uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .en_i(en_i), .irq_en_i(irq_en_i),
        .cfg_wr_i(cfg_wr_i), .cfg_reload_i(cfg_reload_i), .cfg_ext_i(cfg_ext_i),
        .clr_wr_i(clr_wr_i), .clr_data_i(clr_data_i),
        .cfg_ok_o(cfg_ok_o), .status_o(status_o), .irq_o(irq_o)
    );

    function automatic int period_of(int r, bit ext);
        return r + 1 + (ext ? 65536 : 0);
    endfunction

    function automatic bit expiry_at(int cnt, int p);
        return (cnt % p) == 0;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        if (act === exp) pass_n++;
        else begin
            fail_n++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One clock: drive at a falling edge, sample at the next falling edge.
    task automatic step(bit t, bit c, logic [7:0] cd, bit do_chk, string req);
        bit ex;
        @(negedge clk);
        tick_i = t; clr_wr_i = c; clr_data_i = cd;
        @(negedge clk);
        tick_i = 0; clr_wr_i = 0; clr_data_i = '0;
        ex = 0;
        if (t && running) begin
            k++;
            ex = expiry_at(k, per);
        end
        if (ex) mflag = 1;
        else if (c && cd[2]) mflag = 0;
        if (do_chk) begin
            chk(req, 32'(status_o), 32'(mflag) << 2);
            chk(req, 32'(irq_o), 32'(mflag & irq_en_i));
        end
    endtask

    task automatic write_cfg(int r, bit ext);
        @(negedge clk);
        cfg_wr_i = 1; cfg_reload_i = 16'(r); cfg_ext_i = ext;
        @(negedge clk);
        cfg_wr_i = 0;
    endtask

    task automatic enable_timer();
        @(negedge clk);
        en_i = 1;
        repeat (3) @(negedge clk);
        chk("R3 ok before tick", 32'(cfg_ok_o), 1);
        tick_i = 1;
        @(negedge clk);
        tick_i = 0;
        chk("R3 ok right after tick", 32'(cfg_ok_o), 1);
        @(negedge clk);
        chk("R3 ok dropped", 32'(cfg_ok_o), 0);
        running = 1; k = 0;
    endtask

    task automatic disable_timer();
        @(negedge clk);
        en_i = 0; running = 0;
        repeat (3) @(negedge clk);
        chk("R4 ok before tick", 32'(cfg_ok_o), 0);
        tick_i = 1;
        @(negedge clk);
        tick_i = 0;
        chk("R4 ok right after tick", 32'(cfg_ok_o), 0);
        @(negedge clk);
        chk("R4 ok granted", 32'(cfg_ok_o), 1);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                fail_n++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
                finish_run();
            end
        end
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        repeat (4) @(negedge clk);
        chk("R1 ok", 32'(cfg_ok_o), 1);
        chk("R1 status", 32'(status_o), 0);
        chk("R1 irq", 32'(irq_o), 0);
        rst_n = 1;
        irq_en_i = 1;

        // R5 basic period with clears
        write_cfg(3, 0); per = period_of(3, 0);
        enable_timer();
        for (int i = 0; i < 12; i++) begin
            step(1, 0, 8'h00, 1, "R5");
            if (mflag) step(0, 1, 8'h04, 1, "R8");
        end

        // R2 write while running is ignored
        write_cfg(9, 0);
        for (int i = 0; i < 8; i++) step(1, 0, 8'h00, 1, "R2");

        // R10 repeated expiry keeps flag, no other bit
        for (int i = 0; i < 8; i++) step(1, 0, 8'h00, 1, "R10");
        step(0, 1, 8'hFB, 1, "R8 other bits");

        // R9 expiry and clear together
        step(0, 1, 8'h04, 1, "R8");
        while (!expiry_at(k + 1, per)) step(1, 0, 8'h00, 1, "R9 approach");
        step(1, 1, 8'hFF, 1, "R9");

        // R11 gate
        irq_en_i = 0;
        step(0, 0, 8'h00, 1, "R11 gated");
        irq_en_i = 1;
        step(0, 0, 8'h00, 1, "R11 open");

        // R7 restart after partial count, R4 no counting while stopped
        step(0, 1, 8'h04, 1, "R8");
        while (!expiry_at(k + 2, per)) step(1, 0, 8'h00, 1, "R7 partial");
        disable_timer();
        for (int i = 0; i < 5; i++) step(1, 0, 8'h00, 1, "R4 stopped ticks");
        enable_timer();
        for (int i = 0; i < per; i++) step(1, 0, 8'h00, 1, "R7");

        // R12 reload zero
        disable_timer();
        step(0, 1, 8'h04, 1, "R8");
        write_cfg(0, 0); per = period_of(0, 0);
        enable_timer();
        for (int i = 0; i < 6; i++) begin
            step(1, 0, 8'h00, 1, "R12");
            step(0, 1, 8'h04, 1, "R12");
        end

        // Random rounds
        for (int rnd = 0; rnd < 3; rnd++) begin
            int r;
            disable_timer();
            r = int'($urandom_range(0, 7));
            write_cfg(r, 0); per = period_of(r, 0);
            enable_timer();
            for (int i = 0; i < 400; i++) begin
                bit t, c;
                logic [7:0] cd;
                t  = 1'($urandom_range(0, 1));
                c  = ($urandom_range(0, 3) == 0);
                cd = 8'($urandom);
                step(t, c, cd, 1, "R5 random");
            end
        end

        // R6 extended mode
        disable_timer();
        step(0, 1, 8'h04, 1, "R8");
        write_cfg(2, 1); per = period_of(2, 1);
        enable_timer();
        for (int i = 0; i < per - 2; i++) step(1, 0, 8'h00, 0, "R6");
        step(1, 0, 8'h00, 1, "R6 one before");
        step(1, 0, 8'h00, 1, "R6 expiry");

        finish_run();
    end

endmodule